// File: doc/BRIEF.md
# Operand Access Exception Checker

This block screens the operand access of a fixed-point instruction before any architectural state is touched. For each strobed request it looks at the byte address, the operand width, the paired-register number, the installed memory size and the key pair. From these it decides whether an address-class interrupt must be raised. When one is raised, it reports the single cause that wins and how the instruction must end: completed normally, suppressed with no state change, or terminated partway.

The decision is registered, so it appears one cycle after the request. The interrupt request is a one-cycle pulse that accompanies the result. The instruction sequencer uses the disposition to decide whether to roll back or to abandon the instruction. Memory access, the datapath and interrupt vectoring are handled elsewhere.

Top module: `operand_access_checker`

## Requirements
- R1: A request strobed on `req_valid` yields `out_valid` high for exactly one cycle, on the cycle after the strobe. `irq` is high only in a cycle where `out_valid` is high and `cause` is non-zero.
- R2: If `req_pair` is high and `req_reg` is odd, the cause is 1 (register pair) and the disposition is 1 (suppress).
- R3: Alignment is tested on the low address bits of the operand. Size code 1 is a halfword and tests bit 0. Size code 2 is a fullword and tests bits 1:0. Size code 3 is a doubleword and tests bits 2:0. Size code 0 is a byte and is never misaligned. A misaligned operand gives cause 2 (alignment) and disposition 1 (suppress).
- R4: An address greater than or equal to `mem_size` gives cause 3 (out of range) and disposition 2 (terminate).
- R5: A store whose storage key differs from the protection key, with protection enabled, gives cause 4 (protection). The disposition is 1 (suppress), or 2 (terminate) when `req_multi` marks a store-multiple.
- R6: The key comparison has no effect when `prot_en` is low or when the access is not a store.
- R7: When several faults apply, only the highest-priority one is reported. The order is register pair, then alignment, then out of range, then protection.
- R8: A request with no fault reports cause 0 and disposition 0 (complete), with `irq` low.
- R9: In a cycle that follows a cycle without `req_valid`, `out_valid`, `irq`, `cause` and `disp` are all zero.
- R10: While reset is asserted and right after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 fullword, 3 doubleword |
| req_pair | input | 1 | Operand uses an even/odd register pair |
| req_reg | input | REG_W | Register number named for the pair |
| mem_size | input | ADDR_W+1 | Installed memory size in bytes |
| req_store | input | 1 | Access writes memory |
| req_multi | input | 1 | Instruction is a store-multiple |
| prot_en | input | 1 | Memory protection enabled |
| stor_key | input | KEY_W | Storage key of the target location |
| prot_key | input | KEY_W | Protection key of the program |
| out_valid | output | 1 | Result valid, one cycle after request |
| irq | output | 1 | Address-class interrupt request pulse |
| cause | output | 3 | 0 none, 1 pair, 2 alignment, 3 range, 4 protection |
| disp | output | 2 | 0 complete, 1 suppress, 2 terminate |

## Verification
The checker module watches four things on every cycle. It checks the one-cycle pairing of request and result, and that the interrupt pulse always carries a cause. It checks the fixed disposition tied to each cause and the quiet outputs after an idle cycle. It also checks that an odd pair register always wins the arbitration. Only the bench scenarios can show the rest, because these depend on exact address and key values and a reference model: the alignment rules for each width, the exact range boundary, the protection gating by store and enable, the store-multiple exception and the full priority order.

// File: rtl/operand_access_checker.sv
module operand_access_checker #(
  parameter int ADDR_W = 24,
  parameter int KEY_W  = 4,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_pair,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [ADDR_W:0]   mem_size,
  input  logic              req_store,
  input  logic              req_multi,
  input  logic              prot_en,
  input  logic [KEY_W-1:0]  stor_key,
  input  logic [KEY_W-1:0]  prot_key,
  output logic              out_valid,
  output logic              irq,
  output logic [2:0]        cause,
  output logic [1:0]        disp
);

  logic [2:0] amask;
  logic [2:0] nxt_cause;
  logic [1:0] nxt_disp;

  always_comb begin
    case (req_size)
      2'd1:    amask = 3'b001;
      2'd2:    amask = 3'b011;
      2'd3:    amask = 3'b111;
      default: amask = 3'b000;
    endcase
  end

  wire pair_bad  = req_pair & req_reg[0];
  wire align_bad = |(req_addr[2:0] & amask);
  wire range_bad = {1'b0, req_addr} >= mem_size;
  wire prot_bad  = prot_en & req_store & (stor_key != prot_key);

  always_comb begin
    if (pair_bad) begin
      nxt_cause = 3'd1; nxt_disp = 2'd1;
    end else if (align_bad) begin
      nxt_cause = 3'd2; nxt_disp = 2'd1;
    end else if (range_bad) begin
      nxt_cause = 3'd3; nxt_disp = 2'd2;
    end else if (prot_bad) begin
      nxt_cause = 3'd4; nxt_disp = req_multi ? 2'd2 : 2'd1;
    end else begin
      nxt_cause = 3'd0; nxt_disp = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      irq       <= 1'b0;
      cause     <= 3'd0;
      disp      <= 2'd0;
    end else begin
      out_valid <= req_valid;
      irq       <= req_valid & (nxt_cause != 3'd0);
      cause     <= req_valid ? nxt_cause : 3'd0;
      disp      <= req_valid ? nxt_disp  : 2'd0;
    end
  end

endmodule

module operand_access_checker_sva #(
  parameter int REG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_pair,
  input logic [REG_W-1:0] req_reg,
  input logic             out_valid,
  input logic             irq,
  input logic [2:0]       cause,
  input logic [1:0]       disp
);

  a_r1_irq_needs_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out_valid && cause != 3'd0));

  a_r1_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  a_r2_odd_pair_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_pair && req_reg[0]) |=> (irq && cause == 3'd1 && disp == 2'd1));

  a_r3_align_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cause == 3'd2) |-> disp == 2'd1);

  a_r4_range_terminates: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cause == 3'd3) |-> disp == 2'd2);

  a_r5_prot_not_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cause == 3'd4) |-> (disp == 2'd1 || disp == 2'd2));

  a_r8_clean_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cause == 3'd0) |-> (disp == 2'd0 && !irq));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !irq && cause == 3'd0 && disp == 2'd0));

endmodule

bind operand_access_checker operand_access_checker_sva #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pair(req_pair),
  .req_reg(req_reg), .out_valid(out_valid), .irq(irq), .cause(cause), .disp(disp)
);

// File: tb/operand_access_checker_tb_top.sv
`timescale 1ns/1ps
module operand_access_checker_tb_top;
  localparam int ADDR_W = 24;
  localparam int KEY_W  = 4;
  localparam int REG_W  = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_pair = 0, req_store = 0, req_multi = 0, prot_en = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [REG_W-1:0] req_reg = '0;
  logic [ADDR_W:0] mem_size = '0;
  logic [KEY_W-1:0] stor_key = '0, prot_key = '0;
  logic out_valid, irq;
  logic [2:0] cause;
  logic [1:0] disp;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  operand_access_checker #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .REG_W(REG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_pair(req_pair), .req_reg(req_reg), .mem_size(mem_size),
    .req_store(req_store), .req_multi(req_multi), .prot_en(prot_en),
    .stor_key(stor_key), .prot_key(prot_key), .out_valid(out_valid), .irq(irq),
    .cause(cause), .disp(disp));

  function automatic logic [4:0] model(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
      input logic pr, input logic [REG_W-1:0] rg, input logic [ADDR_W:0] ms,
      input logic st, input logic mu, input logic pe, input logic [KEY_W-1:0] sk,
      input logic [KEY_W-1:0] pk);
    int nb = 1 << sz;
    if (pr && (rg % 2 == 1)) return {3'd1, 2'd1};
    if ((a % nb) != 0) return {3'd2, 2'd1};
    if (int'(a) >= int'(ms)) return {3'd3, 2'd2};
    if (pe && st && sk != pk) return {3'd4, mu ? 2'd2 : 2'd1};
    return {3'd0, 2'd0};
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic pr,
      input logic [REG_W-1:0] rg, input logic [ADDR_W:0] ms, input logic st,
      input logic mu, input logic pe, input logic [KEY_W-1:0] sk,
      input logic [KEY_W-1:0] pk, input string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_pair = pr; req_reg = rg;
    mem_size = ms; req_store = st; req_multi = mu; prot_en = pe;
    stor_key = sk; prot_key = pk;
    exp_q.push_back(model(a, sz, pr, rg, ms, st, mu, pe, sk, pk));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R1", $sformatf("unexpected result cause=%0d disp=%0d expected none", cause, disp));
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({cause, disp} == e, t, $sformatf("cause=%0d disp=%0d expected cause=%0d disp=%0d",
                cause, disp, e[4:2], e[1:0]));
          check(irq == (e[4:2] != 0), "R1", $sformatf("irq=%0d expected %0d", irq, e[4:2] != 0));
        end
      end else begin
        check(!irq && cause == 0 && disp == 0, "R9",
              $sformatf("idle irq=%0d cause=%0d disp=%0d expected 0 0 0", irq, cause, disp));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [ADDR_W:0] MS = 25'h10000;

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !irq && cause == 0 && disp == 0, "R10",
          $sformatf("in reset out_valid=%0d irq=%0d cause=%0d disp=%0d expected all 0",
                    out_valid, irq, cause, disp));
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && !irq && cause == 0 && disp == 0, "R10",
          $sformatf("after reset out_valid=%0d irq=%0d expected 0", out_valid, irq));

    // R8: clean accesses of every size
    send(24'h100, 2'd0, 0, 0, MS, 0, 0, 0, 0, 0, "R8");
    send(24'h108, 2'd3, 0, 0, MS, 0, 0, 0, 0, 0, "R8");
    send(24'h104, 2'd2, 0, 0, MS, 0, 0, 0, 0, 0, "R8");
    idle(1);
    // R3: misalignment per size, byte never misaligned
    send(24'h101, 2'd0, 0, 0, MS, 0, 0, 0, 0, 0, "R3");
    send(24'h101, 2'd1, 0, 0, MS, 0, 0, 0, 0, 0, "R3");
    send(24'h102, 2'd1, 0, 0, MS, 0, 0, 0, 0, 0, "R3");
    send(24'h102, 2'd2, 0, 0, MS, 0, 0, 0, 0, 0, "R3");
    send(24'h104, 2'd3, 0, 0, MS, 0, 0, 0, 0, 0, "R3");
    send(24'h10C, 2'd2, 0, 0, MS, 0, 0, 0, 0, 0, "R3");
    idle(2);
    // R2: register pair
    send(24'h200, 2'd3, 1, 4'd3, MS, 0, 0, 0, 0, 0, "R2");
    send(24'h200, 2'd3, 1, 4'd2, MS, 0, 0, 0, 0, 0, "R2");
    send(24'h200, 2'd3, 0, 4'd5, MS, 0, 0, 0, 0, 0, "R2");
    // R4: range boundary
    send(24'hFFFF, 2'd0, 0, 0, MS, 0, 0, 0, 0, 0, "R4");
    send(24'h10000, 2'd0, 0, 0, MS, 0, 0, 0, 0, 0, "R4");
    send(24'h20000, 2'd2, 0, 0, MS, 1, 0, 1, 4'd1, 4'd2, "R4");
    idle(1);
    // R5/R6: protection
    send(24'h300, 2'd2, 0, 0, MS, 1, 0, 1, 4'd5, 4'd6, "R5");
    send(24'h300, 2'd2, 0, 0, MS, 1, 1, 1, 4'd5, 4'd6, "R5");
    send(24'h300, 2'd2, 0, 0, MS, 1, 1, 1, 4'd5, 4'd5, "R5");
    send(24'h300, 2'd2, 0, 0, MS, 1, 0, 0, 4'd5, 4'd6, "R6");
    send(24'h300, 2'd2, 0, 0, MS, 0, 0, 1, 4'd5, 4'd6, "R6");
    // R7: priority
    send(24'h20001, 2'd1, 1, 4'd1, MS, 1, 0, 1, 4'd1, 4'd2, "R7");
    send(24'h20001, 2'd1, 0, 4'd1, MS, 1, 0, 1, 4'd1, 4'd2, "R7");
    send(24'h20000, 2'd1, 0, 4'd1, MS, 1, 1, 1, 4'd1, 4'd2, "R7");
    send(24'h00003, 2'd2, 0, 0, MS, 1, 1, 1, 4'd1, 4'd2, "R7");
    idle(3);
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom_range(0, 32'h13FFF));
      send(a, 2'($urandom), 1'($urandom), REG_W'($urandom), MS, 1'($urandom),
           1'($urandom), 1'($urandom), KEY_W'($urandom_range(0, 2)),
           KEY_W'($urandom_range(0, 2)), "R7");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    check(exp_q.size() == 0, "R1", $sformatf("%0d results missing, expected 0", exp_q.size()));
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule